// File: doc/BRIEF.md
# Delayed-Branch Next-Address Sequencer

This block produces the fetch address stream for a 32-bit RISC pipeline that has one architectural delay slot after every control transfer. It holds three address registers. The current address is the instruction executing now. The next address is the instruction in the delay slot. The one after that is the address that follows the delay slot. The block advances all three by one instruction on every enabled step. A conditional PC-relative branch, a likely branch, an absolute region jump or a register-indirect jump can redirect only the third register. As a result, the delay-slot instruction always reaches the current-address register before the new target does.

For each step the surrounding core supplies a decoded transfer kind, a link request, the evaluated condition, the 16-bit branch offset, the 26-bit jump index and a register operand. The block returns these results:
- the return-address write (enable, register index and address) for link forms;
- an annul flag that marks the delay-slot step of a likely branch that was not taken.

Every pin is a plain control or status signal with no valid/ready handshake. A step happens only when `step_en` is high, and the core stalls the sequencer by holding `step_en` low.

Top module: `nps_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_o` is RESET_VEC, `npc_o` is RESET_VEC+4 and `nnpc_o` is RESET_VEC+8. `link_idx` is always LINK_REG (default 31).
- R2: When `step_en` is low, the three address outputs hold, `link_we` and `annul` are 0, and the transfer inputs leave no trace on any later step.
- R3: Each enabled step with kind 0 (none) moves `npc_o` into `pc_o`, and all three addresses advance by 4. Kinds 5 to 7 behave the same way.
- R4: Kind 1 (branch) with `cond_true`=1 redirects. The offset is shifted left by 2 and sign-extended from bit 17. The step after the branch executes the delay slot (old `npc_o`), and the step after that reaches old `npc_o` plus that displacement, that is, branch address + 4 + displacement.
- R5: Kind 1 with `cond_true`=0 proceeds sequentially and does not annul.
- R6: Kind 2 (likely branch) with `cond_true`=1 behaves as R4. With `cond_true`=0 it raises `annul` for exactly one enabled step: the step whose `pc_o` is the delay slot. Execution then continues at branch address + 8.
- R7: With `link_req`=1 and kind 1 to 4, `link_we` is 1 during that step and `link_addr` equals `pc_o`+8, whether or not the branch is taken.
- R8: Kind 3 (absolute jump) is unconditional. Its target is bits 31:28 of the jump's own `pc_o` followed by `jump_idx` and two zero bits.
- R9: Kind 4 (register jump) is unconditional, and its target is `reg_target`.
- R10: After any redirect, `nnpc_o` equals the new `npc_o` plus 4. In every state, `nnpc_o` is `npc_o`+4.
- R11: During an annulled step, the transfer kind, link request and condition are ignored: no redirect, no link write, and the step is sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance one instruction this cycle |
| xfer_kind | input | 3 | 0 none, 1 branch, 2 likely branch, 3 absolute jump, 4 register jump |
| link_req | input | 1 | Instruction writes a return address |
| cond_true | input | 1 | Evaluated branch condition |
| imm_off | input | 16 | Branch word offset |
| jump_idx | input | 26 | Absolute jump word index |
| reg_target | input | 32 | Register operand for register jumps |
| pc_o | output | 32 | Address of the instruction in this step |
| npc_o | output | 32 | Delay-slot / next address |
| nnpc_o | output | 32 | Address after the next |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Return-address register index |
| link_addr | output | 32 | Return address |
| annul | output | 1 | Current step's instruction is annulled |

## Verification
The bench keeps the default widths and sets RESET_VEC to 0x3FFFFFF0. Sequential stepping therefore crosses from region 3 into region 4 shortly after reset, so an absolute jump checks that its upper bits come from the live address and not from the reset value. Offsets 0xFFFF and 0x8000 cover a branch to its own address and the most negative displacement, and the second one wraps the address through the top of the space.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [2:0] {
    XFER_NONE      = 3'd0,
    XFER_BR        = 3'd1,
    XFER_BR_LIKELY = 3'd2,
    XFER_JUMP_ABS  = 3'd3,
    XFER_JUMP_REG  = 3'd4
  } xfer_e;
endpackage

// File: rtl/nps_target_calc.sv
module nps_target_calc #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26,
  localparam int SH_W  = OFF_W + 2,
  localparam int REG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] npc,
  input  logic [REG_W-1:0]  pc_region,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [IDX_W-1:0]  jump_idx,
  output logic [ADDR_W-1:0] br_tgt,
  output logic [ADDR_W-1:0] jabs_tgt
);
  logic [SH_W-1:0]   shifted;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    shifted  = {imm_off, 2'b00};
    disp     = {{(ADDR_W-SH_W){shifted[SH_W-1]}}, shifted};
    br_tgt   = npc + disp;
    jabs_tgt = {pc_region, jump_idx, 2'b00};
  end
endmodule

// File: rtl/nps_redirect.sv
module nps_redirect
  import nps_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              step_en,
  input  logic              annul_pend,
  input  logic [2:0]        xfer_kind,
  input  logic              link_req,
  input  logic              cond_true,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic [ADDR_W-1:0] jabs_tgt,
  input  logic [ADDR_W-1:0] reg_target,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_tgt,
  output logic              set_pend,
  output logic              annul,
  output logic              link_we
);
  xfer_e kind;

  always_comb begin
    kind         = xfer_e'(xfer_kind);
    redirect     = 1'b0;
    redirect_tgt = br_tgt;
    set_pend     = 1'b0;
    annul        = 1'b0;
    link_we      = 1'b0;
    if (step_en) begin
      if (annul_pend) begin
        annul = 1'b1;
      end else begin
        case (kind)
          XFER_BR: begin
            redirect = cond_true;
            link_we  = link_req;
          end
          XFER_BR_LIKELY: begin
            redirect = cond_true;
            set_pend = !cond_true;
            link_we  = link_req;
          end
          XFER_JUMP_ABS: begin
            redirect     = 1'b1;
            redirect_tgt = jabs_tgt;
            link_we      = link_req;
          end
          XFER_JUMP_REG: begin
            redirect     = 1'b1;
            redirect_tgt = reg_target;
            link_we      = link_req;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nps_pc_regs.sv
module nps_pc_regs #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_tgt,
  input  logic              set_pend,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] nnpc,
  output logic              annul_pend
);
  localparam logic [ADDR_W-1:0] INSN_B = ADDR_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= RESET_VEC;
      npc        <= RESET_VEC + INSN_B;
      nnpc       <= RESET_VEC + INSN_B + INSN_B;
      annul_pend <= 1'b0;
    end else if (step_en) begin
      pc         <= npc;
      annul_pend <= set_pend;
      if (redirect) begin
        npc  <= redirect_tgt;
        nnpc <= redirect_tgt + INSN_B;
      end else begin
        npc  <= nnpc;
        nnpc <= nnpc + INSN_B;
      end
    end
  end
endmodule

// File: rtl/nps_sequencer.sv
module nps_sequencer #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int IDX_W     = 26,
  parameter int RIDX_W    = 5,
  parameter int LINK_REG  = 31,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000,
  localparam int REG_W    = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [2:0]        xfer_kind,
  input  logic              link_req,
  input  logic              cond_true,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [IDX_W-1:0]  jump_idx,
  input  logic [ADDR_W-1:0] reg_target,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic [ADDR_W-1:0] nnpc_o,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [ADDR_W-1:0] link_addr,
  output logic              annul
);
  logic [ADDR_W-1:0] br_tgt, jabs_tgt, redirect_tgt;
  logic redirect, set_pend, annul_pend;

  nps_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .npc(npc_o), .pc_region(pc_o[ADDR_W-1 -: REG_W]), .imm_off(imm_off),
    .jump_idx(jump_idx), .br_tgt(br_tgt), .jabs_tgt(jabs_tgt)
  );

  nps_redirect #(.ADDR_W(ADDR_W)) u_dir (
    .step_en(step_en), .annul_pend(annul_pend), .xfer_kind(xfer_kind),
    .link_req(link_req), .cond_true(cond_true), .br_tgt(br_tgt),
    .jabs_tgt(jabs_tgt), .reg_target(reg_target), .redirect(redirect),
    .redirect_tgt(redirect_tgt), .set_pend(set_pend), .annul(annul),
    .link_we(link_we)
  );

  nps_pc_regs #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_regs (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .redirect(redirect),
    .redirect_tgt(redirect_tgt), .set_pend(set_pend), .pc(pc_o),
    .npc(npc_o), .nnpc(nnpc_o), .annul_pend(annul_pend)
  );

  assign link_idx  = RIDX_W'(LINK_REG);
  assign link_addr = nnpc_o;
endmodule

// File: rtl/nps_sequencer_chk.sv
module nps_sequencer_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] npc_o,
  input logic [ADDR_W-1:0] nnpc_o,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_addr,
  input logic              annul
);
  localparam logic [ADDR_W-1:0] FOUR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] EIGHT = ADDR_W'(8);

  p_reset_vec_r1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == RESET_VEC && npc_o == RESET_VEC + FOUR));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(pc_o) && $stable(npc_o) && $stable(nnpc_o)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> (!link_we && !annul));

  p_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (pc_o == $past(npc_o)));

  p_annul_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    annul |=> !annul);

  p_link_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_addr == pc_o + EIGHT));

  p_nnpc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nnpc_o == npc_o + FOUR);

  p_annul_nolink_r11: assert property (@(posedge clk) disable iff (!rst_n)
    annul |-> !link_we);
endmodule

bind nps_sequencer nps_sequencer_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .pc_o(pc_o), .npc_o(npc_o),
  .nnpc_o(nnpc_o), .link_we(link_we), .link_addr(link_addr), .annul(annul)
);

// File: tb/test_nps_sequencer.sv
module test_nps_sequencer;
  localparam logic [31:0] RV = 32'h3FFF_FFF0;

  logic clk = 1'b0, rst_n = 1'b0, step_en = 1'b0, link_req = 1'b0, cond_true = 1'b0;
  logic [2:0]  xfer_kind = 3'd0;
  logic [15:0] imm_off = '0;
  logic [25:0] jump_idx = '0;
  logic [31:0] reg_target = '0;
  logic [31:0] pc_o, npc_o, nnpc_o, link_addr;
  logic [4:0]  link_idx;
  logic link_we, annul;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nps_sequencer #(.RESET_VEC(RV)) i_nps_sequencer (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .xfer_kind(xfer_kind),
    .link_req(link_req), .cond_true(cond_true), .imm_off(imm_off),
    .jump_idx(jump_idx), .reg_target(reg_target), .pc_o(pc_o), .npc_o(npc_o),
    .nnpc_o(nnpc_o), .link_we(link_we), .link_idx(link_idx),
    .link_addr(link_addr), .annul(annul)
  );

  typedef struct {
    logic [31:0] pc, npc, nnpc, laddr;
    logic lwe, ann;
    string tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_pc, m_npc, m_nnpc;
  logic m_pend;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Driver: applies one step and pushes the expected results from the requirements.
  task automatic drive(input string tag, input logic en, input logic [2:0] kind,
                       input logic lnk, input logic cnd, input logic [15:0] imm,
                       input logic [25:0] idx, input logic [31:0] rt);
    exp_t e;
    logic taken, npend;
    logic [31:0] tgt, disp;
    @(negedge clk); #1;
    step_en = en; xfer_kind = kind; link_req = lnk; cond_true = cnd;
    imm_off = imm; jump_idx = idx; reg_target = rt;
    disp  = {{14{imm[15]}}, imm, 2'b00};
    taken = 0; npend = 0; tgt = m_npc + disp;
    e.tag = tag; e.ann = en && m_pend; e.laddr = m_nnpc;
    e.lwe = en && !m_pend && lnk && (kind >= 3'd1 && kind <= 3'd4);
    if (en && !m_pend) begin
      case (kind)
        3'd1: taken = cnd;
        3'd2: begin taken = cnd; npend = !cnd; end
        3'd3: begin taken = 1; tgt = {m_pc[31:28], idx, 2'b00}; end
        3'd4: begin taken = 1; tgt = rt; end
        default: ;
      endcase
    end
    if (en) begin
      m_pc = m_npc;
      if (taken) begin m_npc = tgt; m_nnpc = tgt + 4; end
      else begin m_npc = m_nnpc; m_nnpc = m_nnpc + 4; end
      m_pend = npend;
    end
    e.pc = m_pc; e.npc = m_npc; e.nnpc = m_nnpc;
    q.push_back(e);
  endtask

  // Monitor: samples combinational results mid-cycle and state after the edge.
  initial begin
    forever begin
      logic lwe_s, ann_s;
      logic [31:0] la_s;
      exp_t e;
      @(negedge clk); #5;
      if (q.size() != 0) begin
        lwe_s = link_we; ann_s = annul; la_s = link_addr;
        @(posedge clk); #1;
        e = q.pop_front();
        chk(e.tag, "link_we", {31'd0, lwe_s}, {31'd0, e.lwe});
        if (e.lwe) chk(e.tag, "link_addr", la_s, e.laddr);
        chk(e.tag, "annul", {31'd0, ann_s}, {31'd0, e.ann});
        chk(e.tag, "pc", pc_o, e.pc);
        chk(e.tag, "npc", npc_o, e.npc);
        chk(e.tag, "nnpc", nnpc_o, e.nnpc);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_pc = RV; m_npc = RV + 4; m_nnpc = RV + 8; m_pend = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "pc", pc_o, RV);
    chk("R1", "npc", npc_o, RV + 4);
    chk("R1", "nnpc", nnpc_o, RV + 8);
    chk("R1", "link_idx", {27'd0, link_idx}, 32'd31);
    @(negedge clk); rst_n = 1'b1;
    // R2 idle with a jump presented: nothing moves
    drive("R2", 0, 3'd3, 1, 1, 16'h0, 26'h0000100, 32'h0);
    // R3 sequential
    drive("R3", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    drive("R3", 1, 3'd6, 1, 1, 16'h0, 26'h0, 32'h0);
    // R5 + R7 branch not taken with link
    drive("R5_R7", 1, 3'd1, 1, 0, 16'h0040, 26'h0, 32'h0);
    drive("R5", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R8 absolute jump in region 4, condition low ignored
    drive("R8", 1, 3'd3, 0, 0, 16'h0, 26'h0000100, 32'h0);
    drive("R10", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R4 taken branch forward
    drive("R4", 1, 3'd1, 0, 1, 16'h0010, 26'h0, 32'h0);
    drive("R4", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R6 likely not taken with link, then annulled slot with a jump presented (R11)
    drive("R6_R7", 1, 3'd2, 1, 0, 16'h0100, 26'h0, 32'h0);
    drive("R11", 1, 3'd4, 1, 1, 16'h0, 26'h0, 32'h0000_9990);
    drive("R6", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R6 likely taken, offset -4 loops to own address
    drive("R6", 1, 3'd2, 0, 1, 16'hFFFF, 26'h0, 32'h0);
    drive("R6", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R9 register jump with link
    drive("R9_R7", 1, 3'd4, 1, 0, 16'h0, 26'h0, 32'h0000_1230);
    drive("R9", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R4 most negative offset wraps
    drive("R4", 1, 3'd1, 0, 1, 16'h8000, 26'h0, 32'h0);
    drive("R4", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    // R2 idle likely-not-taken leaves no pending annul
    drive("R2", 0, 3'd2, 1, 0, 16'h0, 26'h0, 32'h0);
    drive("R2", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    drive("R3", 1, 3'd0, 0, 0, 16'h0, 26'h0, 32'h0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule